// File: doc/BRIEF.md
# Channel Power Control and Thermal Latch Register

This block holds the power and idle settings of a four-channel converter and latches a thermal shutdown event. Software sets a bit for each channel to power it up and picks a single output idle mode, high impedance or a resistor to ground, that applies to every channel that is off. A raw over-temperature indication is synchronised into the clock domain. When it is seen, a sticky flag is set, the active-low alarm output is driven low and every channel enable is forced off. The stored settings are kept while this happens.

A control write does not take effect at once. The block holds it as pending, and commits it only when a later serial frame completes. That later frame can be any write frame, including a no-op, a channel write or another control write. The committed register can be read back continuously. The thermal flag is cleared only when a committed write carries a 0 in the flag position, and the over-temperature input is the only thing that can set it.

Top module: `chan_pwr_ctl`

## Requirements
- R1: After reset, rd_data reads 0x40, ch_en is 0000, idle_hiz is 1 and alarm_n is 1.
- R2: While the thermal flag is clear, ch_en[k] equals committed register bit 2+k: bit 2 drives channel A (ch_en[0]) and bit 5 drives channel D (ch_en[3]). A 1 means powered up.
- R3: idle_hiz equals committed bit 6. A 1 selects high impedance for an off channel and a 0 selects a resistor to ground.
- R4: Bit 1 of rd_data always reads 0, whatever value is written to it.
- R5: Writing 1 to bit 0 never sets the thermal flag. A committed write with 0 in bit 0 clears it.
- R6: A cfg_wr changes nothing on rd_data, ch_en or idle_hiz. The value it carries becomes visible on the clock edge of the next completed frame, which is either a frame_done pulse or a further cfg_wr.
- R7: When a cfg_wr arrives while another value is pending, the older value is committed and the new value becomes the pending one.
- R8: Over-temperature is synchronised through SYNC_STAGES flops. After the third rising edge from the first sampled high ovt_raw (default settings), rd_data bit 0 is 1, alarm_n is 0 and ch_en is 0000. Bits 6 to 2 keep their committed values.
- R9: The flag and the alarm stay asserted after ovt_raw falls, until a clearing write is committed.
- R10: If a clearing write is committed while the synchronised over-temperature is still high, the flag reads 0 for one cycle after the commit and is set again on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe: a control-register frame has completed |
| cfg_wdata | input | 7 | Data carried by the control frame |
| frame_done | input | 1 | One-cycle strobe: any other write frame has completed |
| ovt_raw | input | 1 | Raw over-temperature indication, asynchronous |
| ch_en | output | 4 | Effective power-up enable per channel, A in bit 0 |
| idle_hiz | output | 1 | Idle mode for an off channel: 1 high impedance, 0 resistor to ground |
| alarm_n | output | 1 | Active-low thermal alarm |
| rd_data | output | 7 | Readback of the committed register, including the flag |

## Verification
A committed write shows on the outputs one edge after the strobe that commits it. A cfg_wr on its own shows nothing. The thermal flag appears three edges after ovt_raw is first sampled high, and a clearing commit against a live over-temperature gives exactly one cycle of a clear flag. The driver pushes each expected output set at the falling edge that follows the edge where the result is due. The monitor compares shortly after that falling edge, so the outputs have settled and no further rising edge has yet arrived. Each latency is therefore pinned to a single cycle and not to a window.

// File: rtl/cpr_pkg.sv
// Package: field positions of the channel power control register.
// Assumes channel enables sit in a contiguous field above the reserved bit,
// and that the idle-mode bit sits directly above the last channel bit.
package cpr_pkg;
    localparam int FLAG_BIT = 0;   // sticky thermal shutdown flag
    localparam int RSVD_BIT = 1;   // reserved, reads 0
    localparam int CH_BASE  = 2;   // first channel enable bit

    // Register width for a given channel count: flag, reserved, channels, idle.
    function automatic int reg_width(input int nch);
        return nch + 3;
    endfunction
endpackage

// File: rtl/cpr_sync.sv
// Module: multi-flop synchroniser for the asynchronous over-temperature input.
// Assumes STAGES >= 1; resets to "no over-temperature".
module cpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input in the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= d_async;
                end
            end else begin : g_next
                // Pass the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cpr_stage.sv
// Module: holds a control write as pending until the next completed frame.
// Any completed frame (control or other) commits what is pending. A control
// frame then becomes the new pending value. Assumes strobes last one cycle.
module cpr_stage #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_word,
    input  logic         frame_done,
    output logic         commit,
    output logic [W-1:0] commit_word
);
    logic         pend_vld_q;
    logic [W-1:0] pend_q;
    logic         frame_evt;

    // Any completed frame of either kind.
    assign frame_evt = cfg_wr | frame_done;

    // Release the pending value on a completed frame.
    always_comb begin
        commit      = frame_evt & pend_vld_q;
        commit_word = pend_q;
    end

    // Track whether a value is pending; only a control frame leaves one behind.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_vld_q <= 1'b0;
        else if (frame_evt) pend_vld_q <= cfg_wr;
    end

    // Capture the data of each control frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (cfg_wr) pend_q <= cfg_word;
    end
endmodule

// File: rtl/cpr_core.sv
// Module: committed control bits, sticky thermal flag and derived outputs.
// Assumes commit is a one-cycle pulse and ovt_sync is already synchronised.
// A clearing commit wins over a live over-temperature for one cycle.
module cpr_core #(
    parameter int NUM_CH = 4,
    localparam int CW    = NUM_CH + 1     // channel bits plus idle bit
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [CW-1:0]     commit_ctl,
    input  logic              commit_flag_bit,
    input  logic              ovt_sync,
    output logic [NUM_CH-1:0] ch_en,
    output logic              idle_hiz,
    output logic              alarm_n,
    output logic [CW+1:0]     rd_data
);
    import cpr_pkg::*;

    localparam logic [CW-1:0] CTL_RST = {1'b1, {NUM_CH{1'b0}}};

    logic [CW-1:0] ctl_q;
    logic          flag_q;
    logic          clr_req;

    // A committed word with a 0 in the flag position requests a clear.
    assign clr_req = commit & ~commit_flag_bit;

    // Committed channel enables and idle mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= CTL_RST;
        else if (commit) ctl_q <= commit_ctl;
    end

    // Sticky thermal flag: cleared only by software, set only by the sensor.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (clr_req)  flag_q <= 1'b0;
        else if (ovt_sync) flag_q <= 1'b1;
    end

    // Derive outputs; a set flag overrides every channel enable.
    always_comb begin
        ch_en    = ctl_q[NUM_CH-1:0] & {NUM_CH{~flag_q}};
        idle_hiz = ctl_q[NUM_CH];
        alarm_n  = ~flag_q;
        rd_data  = '0;
        rd_data[CW+CH_BASE-1:CH_BASE] = ctl_q;
        rd_data[FLAG_BIT]             = flag_q;
    end
endmodule

// File: rtl/chan_pwr_ctl.sv
// Module: channel power control register with thermal shutdown latch (top).
// Assumes cfg_wr and frame_done are one-cycle strobes in the clk domain and
// ovt_raw may be asynchronous. The reserved bit of written data is dropped.
module chan_pwr_ctl #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int RW         = cpr_pkg::reg_width(NUM_CH),
    localparam int CW         = NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [RW-1:0]     cfg_wdata,
    input  logic              frame_done,
    input  logic              ovt_raw,
    output logic [NUM_CH-1:0] ch_en,
    output logic              idle_hiz,
    output logic              alarm_n,
    output logic [RW-1:0]     rd_data
);
    import cpr_pkg::*;

    logic          ovt_s;
    logic          commit;
    logic [CW:0]   stage_in;
    logic [CW:0]   stage_out;
    logic          rsvd_unused;

    // Reserved bit carries no state.
    assign rsvd_unused = cfg_wdata[RSVD_BIT];

    // Pack the control field and the flag bit for staging.
    assign stage_in = {cfg_wdata[RW-1:CH_BASE], cfg_wdata[FLAG_BIT]};

    cpr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ovt_raw),
        .q_sync  (ovt_s)
    );

    cpr_stage #(.W(CW + 1)) stage_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_word    (stage_in),
        .frame_done  (frame_done),
        .commit      (commit),
        .commit_word (stage_out)
    );

    cpr_core #(.NUM_CH(NUM_CH)) core_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .commit          (commit),
        .commit_ctl      (stage_out[CW:1]),
        .commit_flag_bit (stage_out[0]),
        .ovt_sync        (ovt_s),
        .ch_en           (ch_en),
        .idle_hiz        (idle_hiz),
        .alarm_n         (alarm_n),
        .rd_data         (rd_data)
    );
endmodule

// File: rtl/chan_pwr_ctl_chk.sv
// Checker: port-level properties of the channel power control register.
module chan_pwr_ctl_chk #(
    parameter int NUM_CH = 4,
    localparam int RW    = NUM_CH + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              frame_done,
    input logic [NUM_CH-1:0] ch_en,
    input logic              alarm_n,
    input logic [RW-1:0]     rd_data
);
    // R8
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_n |-> ch_en == '0);

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] == 1'b0);

    // R6
    no_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr || frame_done) |=> $stable(rd_data[RW-1:1]));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !(cfg_wr || frame_done)) |=> rd_data[0]);

    // R2
    en_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en & ~rd_data[NUM_CH+1:2]) == '0);
endmodule

bind chan_pwr_ctl chan_pwr_ctl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .frame_done (frame_done),
    .ch_en      (ch_en),
    .alarm_n    (alarm_n),
    .rd_data    (rd_data)
);

// File: tb/chan_pwr_ctl_tb_top.sv
module chan_pwr_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       frame_done = 1'b0;
    logic       ovt_raw = 1'b0;
    logic [3:0] ch_en;
    logic       idle_hiz;
    logic       alarm_n;
    logic [6:0] rd_data;

    typedef struct {
        string      tag;
        logic [6:0] rd;
        logic [3:0] en;
        logic       idle;
        logic       alm;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    chan_pwr_ctl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .frame_done (frame_done),
        .ovt_raw    (ovt_raw),
        .ch_en      (ch_en),
        .idle_hiz   (idle_hiz),
        .alarm_n    (alarm_n),
        .rd_data    (rd_data)
    );

    task automatic push(input string tag, input logic [6:0] rd, input logic [3:0] en,
                        input logic idle, input logic alm);
        exp_t e;
        e.tag = tag; e.rd = rd; e.en = en; e.idle = idle; e.alm = alm;
        exp_q.push_back(e);
    endtask

    task automatic cfg_write(input logic [6:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare every queued expectation shortly after a falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (rd_data !== e.rd || ch_en !== e.en || idle_hiz !== e.idle || alarm_n !== e.alm) begin
                    n_fail++;
                    $display("FAIL %s: got rd=%h en=%b idle=%b alm=%b, expected rd=%h en=%b idle=%b alm=%b",
                             e.tag, rd_data, ch_en, idle_hiz, alarm_n, e.rd, e.en, e.idle, e.alm);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 reset state", 7'h40, 4'b0000, 1'b1, 1'b1);

        // R6: staged write invisible until the next frame
        cfg_write(7'h3C);
        push("R6 pending not visible", 7'h40, 4'b0000, 1'b1, 1'b1);
        frame();
        push("R2 R3 R6 commit all on, grounded idle", 7'h3C, 4'b1111, 1'b0, 1'b1);

        // R4 R5: reserved bit and flag bit written as 1
        cfg_write(7'h47);
        frame();
        push("R4 R5 reserved and flag ignored", 7'h44, 4'b0001, 1'b1, 1'b1);

        // R7: back-to-back control writes
        cfg_write(7'h28);
        push("R7 second write commits first", 7'h44, 4'b0001, 1'b1, 1'b1);
        cfg_write(7'h10);
        push("R7 first value committed", 7'h28, 4'b1010, 1'b0, 1'b1);
        frame();
        push("R7 second value committed", 7'h10, 4'b0100, 1'b0, 1'b1);

        // R8: latency of the thermal flag
        @(negedge clk);
        ovt_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        push("R8 flag not yet after two edges", 7'h10, 4'b0100, 1'b0, 1'b1);
        @(negedge clk);
        push("R8 flag set on third edge, channels off", 7'h11, 4'b0000, 1'b0, 1'b0);

        // R9: sticky after recovery
        ovt_raw = 1'b0;
        idle_cycles(6);
        push("R9 flag persists after recovery", 7'h11, 4'b0000, 1'b0, 1'b0);

        // R10: clear while over-temperature still present
        ovt_raw = 1'b1;
        idle_cycles(4);
        cfg_write(7'h10);
        frame();
        push("R10 flag clear for one cycle", 7'h10, 4'b0100, 1'b0, 1'b1);
        @(negedge clk);
        push("R10 flag set again", 7'h11, 4'b0000, 1'b0, 1'b0);

        // R5: writing 1 to the flag bit does not clear it
        ovt_raw = 1'b0;
        idle_cycles(4);
        cfg_write(7'h7D);
        frame();
        push("R5 writing 1 keeps flag", 7'h7D, 4'b0000, 1'b1, 1'b0);

        // R5 R9: clearing write releases the alarm
        cfg_write(7'h3C);
        cfg_write(7'h24);
        push("R5 clearing write commits", 7'h3C, 4'b1111, 1'b0, 1'b1);
        frame();
        push("R2 channels A and D only", 7'h24, 4'b1001, 1'b0, 1'b1);

        // R6: simultaneous control and other frame
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 7'h58; frame_done = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; frame_done = 1'b0;
        push("R6 same-cycle frame does not commit own data", 7'h24, 4'b1001, 1'b0, 1'b1);
        frame();
        push("R3 R6 high-z idle, B and C", 7'h58, 4'b0110, 1'b1, 1'b1);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 reset restores default", 7'h40, 4'b0000, 1'b1, 1'b1);

        idle_cycles(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule